// File: doc/BRIEF.md
# PDM Microphone Capture Front End

This block turns the one-bit pulse-density stream from one or two digital microphones on a shared data line into signed 24-bit PCM samples. It drives the microphone clock by dividing the system clock. It splits the shared line into a left and a right bit stream according to which clock edge each bit belongs to. Each stream passes through a fourth-order CIC decimator, and a Q23 gain multiplier follows the decimators.

Software-facing logic owns the four configuration inputs:
- the oversampling ratio code,
- the channel mode,
- the edge polarity swap,
- the gain word.

Samples leave the block on a single registered stream. A tag on that stream marks each sample as left or right. In stereo mode the two samples of a pair leave on consecutive cycles, with left first. If the ratio or the channel mode changes while the block is enabled, the filters restart from a clean state.

Top module: `pdm_capture`

## Requirements
- R1: The `osr_sel` input sets the decimation ratio R: code 0 gives 64, code 1 gives 128, and codes 2 and 3 both give 256 microphone clock periods per output sample.
- R2: While `en` is high, `pdm_clk` has a period of 2*HALF_DIV system cycles. Each active channel produces exactly one sample every R rising edges of `pdm_clk`.
- R3: The `chan_mode` input selects which channels produce samples: 1 is left only, 2 is right only, 3 is stereo, and 0 gives no output. The tag `pcm_right` is 0 for a left sample and 1 for a right sample.
- R4: With `edge_swap`=0, the bit present on `pdm_data` just before a rising edge of `pdm_clk` belongs to the left channel, and the bit present just before a falling edge belongs to the right channel. With `edge_swap`=1 the two edges trade channels.
- R5: The `gain` input is an unsigned Q23 multiplier, where 0x800000 is unity. The result is the scaled sample times gain, plus 2^22, shifted arithmetically right by 23 bits, then saturated to the range -0x800000 to 0x7FFFFF.
- R6: A data bit of 1 counts as +1 and a bit of 0 counts as -1. At unity gain, after the filter settles, the output does not depend on the ratio:
  - all ones gives 0x7FFFFF;
  - all zeros gives 0x800000;
  - three ones in every four bits gives 0x400000;
  - alternating bits give 0.
- R7: In stereo mode each left sample is followed, on the very next cycle, by its right sample.
- R8: A change of `osr_sel` or `chan_mode` while `en` is high clears the filter state and restarts the clock. No new sample appears until R rising edges of `pdm_clk` (for the new R) have passed since the change.
- R9: While `en` is low, `pdm_clk` stays low and no sample is produced once the output pipeline has drained, which takes at most four cycles.
- R10: During reset `pcm_valid` and `pdm_clk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable |
| osr_sel | input | 2 | Oversampling ratio code |
| chan_mode | input | 2 | Channel mode: 1 left, 2 right, 3 stereo |
| edge_swap | input | 1 | Swaps which clock edge feeds each channel |
| gain | input | 24 | Q23 gain word, 0x800000 = unity |
| pdm_data | input | 1 | Shared microphone data line |
| pdm_clk | output | 1 | Microphone clock |
| pcm_valid | output | 1 | Output sample strobe |
| pcm_right | output | 1 | Channel tag of the output sample |
| pcm_data | output | 24 | Signed PCM sample |

## Verification
The properties assume that the configuration inputs stay steady between changes. The mode, pairing and spacing checks apply only after six quiet cycles, which keeps the samples still draining from an old configuration out of them. The bench always changes configuration in one step, either with `en` low or right after a completed stereo pair. It drives the data line from the level of `pdm_clk`, so each bit is in place a full half period before the edge that samples it. The bench uses periodic bit patterns whose period divides every ratio, so the settled CIC output can be worked out exactly.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_LEFT  = 2'd1,
    MODE_RIGHT = 2'd2,
    MODE_BOTH  = 2'd3
  } chan_mode_e;

  localparam int LG_BASE = 6;   // log2 of the smallest ratio
  localparam int LG_MAX  = 8;   // log2 of the largest ratio

  function automatic logic [3:0] ratio_lg(input logic [1:0] code);
    return 4'(LG_BASE) + ((code >= 2'd2) ? 4'd2 : {2'b00, code});
  endfunction
endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic pdm_in,
  output logic mic_clk,
  output logic rise_ev,
  output logic fall_ev,
  output logic bit_q
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] div_cnt;
  logic          at_end;

  assign at_end = (div_cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt <= '0;
      mic_clk <= 1'b0;
      rise_ev <= 1'b0;
      fall_ev <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      rise_ev <= at_end && !mic_clk;
      fall_ev <= at_end && mic_clk;
      if (at_end) begin
        div_cnt <= '0;
        mic_clk <= !mic_clk;
        bit_q   <= pdm_in;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdm_cic.sv
module pdm_cic #(
  parameter int ORDER = 4,
  parameter int W     = 34
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                in_ev,
  input  logic                in_bit,
  input  logic                dump,
  output logic                out_vld,
  output logic signed [W-1:0] out_val
);
  logic signed [W-1:0] integ [ORDER];
  logic signed [W-1:0] dly   [ORDER];
  logic signed [W-1:0] stage [ORDER+1];
  logic signed [W-1:0] step;

  assign step     = in_bit ? W'(1) : {W{1'b1}};
  assign stage[0] = integ[ORDER-1];

  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    assign stage[k+1] = stage[k] - dly[k];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < ORDER; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
      out_val <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= dump;
      if (in_ev) begin
        integ[0] <= integ[0] + step;
        for (int k = 1; k < ORDER; k++) integ[k] <= integ[k] + integ[k-1];
      end
      if (dump) begin
        for (int k = 0; k < ORDER; k++) dly[k] <= stage[k];
        out_val <= stage[ORDER];
      end
    end
  end
endmodule

// File: rtl/pdm_gain.sv
module pdm_gain #(
  parameter int W  = 34,
  parameter int DW = 24,
  parameter int GW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic                 in_right,
  input  logic signed [W-1:0]  in_val,
  input  logic [5:0]           shamt,
  input  logic [GW-1:0]        gain,
  output logic                 pcm_valid,
  output logic                 pcm_right,
  output logic [DW-1:0]        pcm_data
);
  localparam int PW = DW + GW + 1;
  localparam logic signed [DW-1:0] DMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [W-1:0]  WHI  = W'(DMAX);
  localparam logic signed [W-1:0]  WLO  = W'(DMIN);
  localparam logic signed [PW-1:0] PHI  = PW'(DMAX);
  localparam logic signed [PW-1:0] PLO  = PW'(DMIN);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (GW - 2);

  logic signed [W-1:0]  scaled;
  logic signed [DW-1:0] s1_val;
  logic                 s1_vld, s1_right;
  logic signed [PW-1:0] prod, rnd, shr;

  assign scaled = in_val >>> shamt;
  assign prod   = s1_val * $signed({1'b0, gain});
  assign rnd    = prod + HALF;
  assign shr    = rnd >>> (GW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld    <= 1'b0;
      s1_right  <= 1'b0;
      s1_val    <= '0;
      pcm_valid <= 1'b0;
      pcm_right <= 1'b0;
      pcm_data  <= '0;
    end else begin
      s1_vld   <= in_vld;
      s1_right <= in_right;
      if (scaled > WHI)      s1_val <= DMAX;
      else if (scaled < WLO) s1_val <= DMIN;
      else                   s1_val <= scaled[DW-1:0];

      pcm_valid <= s1_vld;
      pcm_right <= s1_right;
      if (shr > PHI)      pcm_data <= DMAX;
      else if (shr < PLO) pcm_data <= DMIN;
      else                pcm_data <= shr[DW-1:0];
    end
  end
endmodule

// File: rtl/pdm_capture.sv
module pdm_capture
  import pdm_cap_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int DW       = 24,
  parameter int GW       = 24,
  parameter int ORDER    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    osr_sel,
  input  logic [1:0]    chan_mode,
  input  logic          edge_swap,
  input  logic [GW-1:0] gain,
  input  logic          pdm_data,
  output logic          pdm_clk,
  output logic          pcm_valid,
  output logic          pcm_right,
  output logic [DW-1:0] pcm_data
);
  localparam int W   = ORDER * LG_MAX + 2;
  localparam int PCW = LG_MAX;

  logic [1:0]     osr_q, mode_q;
  logic           flush, run;
  logic [3:0]     lg;
  logic [PCW-1:0] last_cnt, per_cnt;
  logic [5:0]     shamt;
  logic           rise_ev, fall_ev, bit_q, dump_q;
  logic           ch_ev  [2];
  logic           ch_vld [2];
  logic signed [W-1:0] ch_val [2];
  logic           cic_go, take_left, r_pend;
  logic           g_vld, g_right;
  logic signed [W-1:0] g_val;

  always_ff @(posedge clk) begin
    osr_q  <= osr_sel;
    mode_q <= chan_mode;
  end

  assign flush    = en && ((osr_sel != osr_q) || (chan_mode != mode_q));
  assign run      = en && !flush;
  assign lg       = ratio_lg(osr_sel);
  assign last_cnt = PCW'((1 << lg) - 1);
  assign shamt    = 6'(ORDER * int'(lg) - (DW - 1));

  pdm_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
    .clk(clk), .rst(rst), .run(run), .pdm_in(pdm_data),
    .mic_clk(pdm_clk), .rise_ev(rise_ev), .fall_ev(fall_ev), .bit_q(bit_q)
  );

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      per_cnt <= '0;
      dump_q  <= 1'b0;
    end else begin
      dump_q <= fall_ev && (per_cnt == last_cnt);
      if (fall_ev) per_cnt <= (per_cnt == last_cnt) ? '0 : per_cnt + 1'b1;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    if (ch == 0) begin : g_l
      assign ch_ev[ch] = edge_swap ? fall_ev : rise_ev;
    end else begin : g_r
      assign ch_ev[ch] = edge_swap ? rise_ev : fall_ev;
    end
    pdm_cic #(.ORDER(ORDER), .W(W)) cic_i (
      .clk(clk), .rst(rst), .clr(!run), .in_ev(ch_ev[ch]), .in_bit(bit_q),
      .dump(dump_q), .out_vld(ch_vld[ch]), .out_val(ch_val[ch])
    );
  end

  assign cic_go    = ch_vld[0] && ch_vld[1];
  assign take_left = cic_go && chan_mode[0];

  always_ff @(posedge clk) begin
    if (rst || !run) r_pend <= 1'b0;
    else             r_pend <= cic_go && chan_mode[1];
  end

  assign g_vld   = take_left || r_pend;
  assign g_right = !take_left;
  assign g_val   = take_left ? ch_val[0] : ch_val[1];

  pdm_gain #(.W(W), .DW(DW), .GW(GW)) gain_i (
    .clk(clk), .rst(rst), .in_vld(g_vld), .in_right(g_right), .in_val(g_val),
    .shamt(shamt), .gain(gain), .pcm_valid(pcm_valid), .pcm_right(pcm_right),
    .pcm_data(pcm_data)
  );
endmodule

// File: rtl/pdm_capture_chk.sv
module pdm_capture_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [1:0] osr_sel,
  input logic [1:0] chan_mode,
  input logic       pdm_clk,
  input logic       pcm_valid,
  input logic       pcm_right
);
  logic [4:0] cfg_now, cfg_prev;
  logic [3:0] age;
  logic [9:0] rises, r_need;
  logic       prev_clk, quiet;

  assign cfg_now = {en, osr_sel, chan_mode};
  assign quiet   = (age >= 4'd6) && (cfg_now == cfg_prev);

  always_comb begin
    case (osr_sel)
      2'd0:    r_need = 10'd64;
      2'd1:    r_need = 10'd128;
      default: r_need = 10'd256;
    endcase
  end

  always_ff @(posedge clk) begin
    cfg_prev <= cfg_now;
    prev_clk <= pdm_clk;
    if (rst || (cfg_now != cfg_prev)) begin
      age   <= '0;
      rises <= '0;
    end else begin
      if (age != 4'hF) age <= age + 1'b1;
      if (pdm_clk && !prev_clk && rises != 10'h3FF) rises <= rises + 1'b1;
    end
  end

  p_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (pcm_valid && quiet) |-> (rises >= r_need));

  p_mode_r3: assert property (@(posedge clk) disable iff (rst)
    (pcm_valid && quiet) |-> (pcm_right ? chan_mode[1] : chan_mode[0]));

  p_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (pcm_valid && !pcm_right && chan_mode == 2'b11 && quiet) |=> (pcm_valid && pcm_right));

  p_idle_clk_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pdm_clk);

  p_idle_out_r9: assert property (@(posedge clk) disable iff (rst)
    (!en && quiet) |-> !pcm_valid);
endmodule

bind pdm_capture pdm_capture_chk chk_i (
  .clk(clk), .rst(rst), .en(en), .osr_sel(osr_sel), .chan_mode(chan_mode),
  .pdm_clk(pdm_clk), .pcm_valid(pcm_valid), .pcm_right(pcm_right)
);

// File: tb/pdm_capture_tb_top.sv
module pdm_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  osr_sel = 2'd0;
  logic [1:0]  chan_mode = 2'd3;
  logic        edge_swap = 1'b0;
  logic [23:0] gain = 24'h800000;
  logic        pdm_data = 1'b0;
  logic        pdm_clk, pcm_valid, pcm_right;
  logic [23:0] pcm_data;

  always #5 clk = !clk;

  pdm_capture #(.HALF_DIV(1)) dut_i (
    .clk(clk), .rst(rst), .en(en), .osr_sel(osr_sel), .chan_mode(chan_mode),
    .edge_swap(edge_swap), .gain(gain), .pdm_data(pdm_data), .pdm_clk(pdm_clk),
    .pcm_valid(pcm_valid), .pcm_right(pcm_right), .pcm_data(pcm_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // pattern kinds: 0 all zeros, 1 all ones, 2 three of four ones, 3 alternating
  int kind_a = 1, kind_b = 0;
  int ia = 0, ib = 0;
  logic drv_prev = 1'b0;

  function automatic logic pat(int kind, int idx);
    case (kind)
      0: return 1'b0;
      1: return 1'b1;
      2: return (idx % 4) != 3;
      default: return idx[0];
    endcase
  endfunction

  // data for the next rising edge while clock is low, next falling edge while high
  always @(negedge clk) begin
    if (pdm_clk && !drv_prev) ia++;
    if (!pdm_clk && drv_prev) ib++;
    drv_prev = pdm_clk;
    pdm_data = pdm_clk ? pat(kind_b, ib) : pat(kind_a, ia);
  end

  int nl = 0, nr = 0, nv = 0, pair_err = 0, hi_cnt = 0;
  int rises_l = 0, rises_r = 0, gap_l = 0, gap_r = 0;
  int cyc_rise = 0, last_per = 0, rises_arm = 0, first_gap = -1;
  bit armed = 0, stereo_chk = 0;
  logic [23:0] last_l = '0, last_r = '0;
  logic mon_prev = 1'b0, prev_left_v = 1'b0;

  always @(negedge clk) begin
    cyc_rise++;
    if (pdm_clk && !mon_prev) begin
      last_per = cyc_rise; cyc_rise = 0;
      rises_l++; rises_r++; rises_arm++;
    end
    if (pdm_clk) hi_cnt++;
    mon_prev = pdm_clk;
    if (pcm_valid) begin
      nv++;
      if (!pcm_right) begin
        nl++; last_l = pcm_data; gap_l = rises_l; rises_l = 0;
      end else begin
        nr++; last_r = pcm_data; gap_r = rises_r; rises_r = 0;
        if (stereo_chk && !prev_left_v) pair_err++;
      end
      if (armed) begin first_gap = rises_arm; armed = 0; end
    end
    prev_left_v = pcm_valid && !pcm_right;
  end

  function automatic int pre_val(int kind);
    case (kind)
      0: return -8388608;
      1: return 8388607;
      2: return 4194304;
      default: return 0;
    endcase
  endfunction

  function automatic logic [23:0] expect_out(int kind, logic [23:0] g);
    longint p;
    p = longint'(pre_val(kind)) * longint'({8'd0, g}) + 64'sd4194304;
    p = p >>> 23;
    if (p > 64'sd8388607) p = 64'sd8388607;
    if (p < -64'sd8388608) p = -64'sd8388608;
    return p[23:0];
  endfunction

  task automatic check(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic clear_mon();
    nl = 0; nr = 0; nv = 0; pair_err = 0; hi_cnt = 0;
    rises_l = 0; rises_r = 0;
  endtask

  task automatic start(input logic [1:0] o, input logic [1:0] m, input logic sw,
                       input logic [23:0] g, input int ka, input int kb);
    en = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    osr_sel = o; chan_mode = m; edge_swap = sw; gain = g;
    kind_a = ka; kind_b = kb;
    stereo_chk = (m == 2'd3);
    clear_mon();
    en = 1'b1;
  endtask

  task automatic wait_outs(int want_l, int want_r);
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); #1;
      if (nl >= want_l && nr >= want_r) break;
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 pcm_valid in reset", pcm_valid, 0);
    check("R10 pdm_clk in reset", pdm_clk, 0);
    rst = 1'b0;

    // R4 R6: stereo, full scale, normal polarity
    start(2'd0, 2'd3, 1'b0, 24'h800000, 1, 0);
    wait_outs(6, 6);
    check("R4 R6 left all ones", last_l, 24'h7FFFFF);
    check("R4 R6 right all zeros", last_r, 24'h800000);
    check("R7 stereo pairing", pair_err, 0);

    // R4: swapped polarity
    start(2'd0, 2'd3, 1'b1, 24'h800000, 1, 0);
    wait_outs(6, 6);
    check("R4 swapped left", last_l, 24'h800000);
    check("R4 swapped right", last_r, 24'h7FFFFF);

    // R1 R2 R6: each ratio code with density patterns
    for (int o = 0; o < 4; o++) begin
      start(2'(o), 2'd3, 1'b0, 24'h800000, 2, 3);
      wait_outs(6, 6);
      check($sformatf("R6 osr%0d left 3/4", o), last_l, 24'h400000);
      check($sformatf("R6 osr%0d right alternating", o), last_r, 24'h000000);
      check($sformatf("R1 R2 osr%0d left spacing", o), gap_l, (o >= 2) ? 256 : (64 << o));
      check($sformatf("R2 osr%0d right spacing", o), gap_r, (o >= 2) ? 256 : (64 << o));
      check($sformatf("R7 osr%0d pairing", o), pair_err, 0);
      check($sformatf("R2 osr%0d clock period", o), last_per, 2);
    end

    // R3: left only, right only, none
    start(2'd0, 2'd1, 1'b0, 24'h800000, 2, 1);
    wait_outs(6, 0);
    check("R3 left only value", last_l, 24'h400000);
    check("R3 left only no right", nr, 0);
    start(2'd0, 2'd2, 1'b0, 24'h800000, 2, 1);
    wait_outs(0, 6);
    check("R3 right only value", last_r, 24'h7FFFFF);
    check("R3 right only no left", nl, 0);
    start(2'd0, 2'd0, 1'b0, 24'h800000, 2, 1);
    repeat (600) @(posedge clk);
    #1;
    check("R3 mode none no output", nv, 0);

    // R5: gain, rounding and saturation
    begin
      logic [23:0] gl [3];
      gl[0] = 24'h400000; gl[1] = 24'hFFFFFF; gl[2] = 24'h000001;
      for (int k = 0; k < 3; k++) begin
        start(2'd0, 2'd3, 1'b0, gl[k], 2, 0);
        wait_outs(6, 6);
        check($sformatf("R5 gain %0h left", gl[k]), last_l, expect_out(2, gl[k]));
        check($sformatf("R5 gain %0h right", gl[k]), last_r, expect_out(0, gl[k]));
      end
    end

    // R8: ratio change while enabled restarts
    start(2'd0, 2'd3, 1'b0, 24'h800000, 2, 3);
    wait_outs(4, 4);
    begin
      int seen;
      seen = nr;
      for (int i = 0; i < 2000; i++) begin
        @(posedge clk); #1;
        if (nr != seen) break;
      end
    end
    osr_sel = 2'd1;
    rises_arm = 0; first_gap = -1; armed = 1;
    clear_mon();
    wait_outs(6, 6);
    checks++;
    if (first_gap < 128 || first_gap > 131) begin
      errors++;
      $display("FAIL R8 rises before first sample after change actual %0d expected 128..131", first_gap);
    end
    check("R8 settled value at new ratio", last_l, 24'h400000);
    check("R8 spacing at new ratio", gap_l, 128);

    // R9: disable
    en = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    clear_mon();
    repeat (300) @(posedge clk);
    #1;
    check("R9 no output while disabled", nv, 0);
    check("R9 clock idle while disabled", hi_cnt, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule